// File: doc/BRIEF.md
# Serial status register write guard

This block is the part of a serial memory's SPI slave interface that handles writes to the status register. It oversamples the SPI clock, data-in and active-low select with the system clock. It decodes 8-bit opcodes, sent most significant bit first, and keeps a status byte. That byte holds four block-protect bits, a lock bit and a write-enable latch.

A status write takes two select frames. The first frame carries one of two enable opcodes and sets the write-enable latch. The second frame carries the write-status opcode and one data byte. The new value is committed only when select is released. An active-low write-protect input and the lock bit together decide whether the data byte is taken. While write-protect is held low, the lock bit can be set but never cleared. Once the lock bit is set under that condition, the whole command is refused. The serial output is never driven, so the block has no output pin for it.

Top module: `spi_status_guard`

## Requirements
- R1: After reset, status_o is 8'h00.
- R2: A select frame of exactly 8 bits holding opcode 8'h06 or 8'h50 sets the write-enable latch, which is status_o[1], when select rises.
- R3: A frame of exactly 16 bits that starts with opcode 8'h01 is accepted when the latch is set and wp_n is high. On the rise of select, status_o[7] takes data bit 7 and status_o[5:2] take data bits 5:2. This includes clearing the lock bit.
- R4: A write-status frame received while the latch is clear leaves status_o[7] and status_o[5:2] unchanged.
- R5: When wp_n is low and status_o[7] is 1, a write-status frame leaves status_o[7] and status_o[5:2] unchanged.
- R6: When wp_n is low and status_o[7] is 0, an accepted frame sets the lock bit and the block-protect bits in one update. A later frame that tries to clear the lock bit while wp_n stays low has no effect.
- R7: Any frame whose first 8 bits are 8'h01 clears the write-enable latch when select rises, whether or not it was accepted.
- R8: A frame released before its bit count matches the opcode is discarded and leaves the protect and lock bits unchanged. Exact counts are 8 bits for an enable opcode and 16 bits for write-status.
- R9: status_o changes only in the cycle after a select rise is detected. status_o[6] and status_o[0] always read 0.
- R10: Frames that start with the clock idle low (mode 0) and frames that start with it idle high (mode 3) are both decoded. Data is sampled on rising clock edges.
- R11: Clock edges while select is high have no effect on status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Active-low write-protect pin |
| status_o | output | 8 | Status: [7] lock, [5:2] block protect, [1] write-enable latch |

## Verification
The assertions check on every cycle that the protect and lock bits hold still unless select has just risen. They also check that a refused write leaves those bits alone, whether it was refused for a missing latch, for a lock under write-protect, or for a short frame, and that a write-status frame always leaves the latch clear. The bench scenarios cover what only a full command sequence can show: the enable-then-write sequence in both clock modes, setting the lock together with the protect bits, the lock being impossible to clear while protected, and clearing it again once write-protect is released.

// File: rtl/spi_status_guard.sv
module spi_status_guard #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_EWSR = 8'h50,
  parameter logic [7:0] OP_WRSR = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       wp_n,
  output logic [7:0] status_o
);
  localparam int CW   = 5;
  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [CW-1:0] SAT = CW'(17);

  logic [SYNC_STAGES:0]   sck_p, cs_p, si_p;
  logic [SYNC_STAGES-1:0] wp_p;
  logic [CW-1:0] cnt;
  logic [7:0]    sh, op;
  logic          wel, lock;
  logic [3:0]    bp;

  wire sck_rise = sck_p[LAST] & ~sck_p[SYNC_STAGES];
  wire cs_high  = cs_p[LAST];
  wire cs_rise  = cs_p[LAST] & ~cs_p[SYNC_STAGES];
  wire si_now   = si_p[LAST];
  wire wp_now   = wp_p[LAST];
  wire is_en    = (cnt == CW'(8)) && (op == OP_WREN || op == OP_EWSR);
  wire is_wrsr  = (cnt >= CW'(8)) && (op == OP_WRSR);
  wire take     = is_wrsr && (cnt == CW'(16)) && wel && (wp_now || !lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
      wp_p  <= '1;
    end else begin
      sck_p <= {sck_p[SYNC_STAGES-1:0], spi_sck};
      cs_p  <= {cs_p[SYNC_STAGES-1:0], spi_cs_n};
      si_p  <= {si_p[SYNC_STAGES-1:0], spi_mosi};
      wp_p  <= {wp_p[SYNC_STAGES-2:0], wp_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
      op  <= '0;
    end else if (cs_high) begin
      cnt <= '0;
    end else if (sck_rise) begin
      sh <= {sh[6:0], si_now};
      if (cnt == CW'(7)) op <= {sh[6:0], si_now};
      if (cnt != SAT) cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      lock <= 1'b0;
      bp   <= '0;
    end else if (cs_rise) begin
      if (is_en) wel <= 1'b1;
      if (is_wrsr) wel <= 1'b0;
      if (take) begin
        lock <= sh[7];
        bp   <= sh[5:2];
      end
    end
  end

  assign status_o = {lock, 1'b0, bp, wel, 1'b0};

  p_hold_between_frames_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(status_o))
    else $error("status changed without select rise");

  p_locked_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !wp_now && lock) |=> $stable({status_o[7], status_o[5:2]}))
    else $error("locked status was written");

  p_need_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !wel) |=> $stable({status_o[7], status_o[5:2]}))
    else $error("write without enable latch");

  p_short_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != CW'(16)) |=> $stable({status_o[7], status_o[5:2]}))
    else $error("short frame changed protect bits");

  p_latch_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && is_wrsr) |=> !status_o[1])
    else $error("latch survived write-status frame");

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_now && status_o[7]) |=> status_o[7])
    else $error("lock cleared while protected");
endmodule

// File: tb/tb_spi_status_guard.sv
module tb_spi_status_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic [7:0] status;
  int checks = 0, fails = 0;
  localparam int HALF = 4;

  always #5 clk = ~clk;

  spi_status_guard dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .wp_n(wp_n), .status_o(status)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s status=%h expected=%h", req, status, exp);
    end
  endtask

  task automatic frame(input logic [15:0] val, input int nbits, input bit m3);
    sck = m3;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      mosi = val[15-i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
    if (!m3) sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_reset;
    check("R1 reset", 8'h00);
  endtask

  task automatic t_no_latch;
    frame({8'h01, 8'h3C}, 16, 1'b0);
    check("R4 no latch", 8'h00);
  endtask

  task automatic t_mode0_write;
    frame({8'h06, 8'h00}, 8, 1'b0);
    check("R2 wren latch", 8'h02);
    frame({8'h01, 8'h3C}, 16, 1'b0);
    check("R3 R7 mode0 write", 8'h3C);
  endtask

  task automatic t_mode3_write;
    frame({8'h50, 8'h00}, 8, 1'b1);
    check("R2 R10 ewsr mode3", 8'h3E);
    frame({8'h01, 8'hFF}, 16, 1'b1);
    check("R9 R10 mode3 write", 8'hBC);
  endtask

  task automatic t_locked;
    wp_n = 1'b0;
    frame({8'h06, 8'h00}, 8, 1'b0);
    check("R2 latch under wp", 8'hBE);
    frame({8'h01, 8'h00}, 16, 1'b0);
    check("R5 R7 locked ignored", 8'hBC);
  endtask

  task automatic t_unprotect_clear;
    wp_n = 1'b1;
    frame({8'h06, 8'h00}, 8, 1'b0);
    frame({8'h01, 8'h00}, 16, 1'b0);
    check("R3 lock cleared wp high", 8'h00);
  endtask

  task automatic t_wp_low_set;
    wp_n = 1'b0;
    frame({8'h06, 8'h00}, 8, 1'b1);
    frame({8'h01, 8'h88}, 16, 1'b1);
    check("R6 set lock and bp", 8'h88);
    frame({8'h06, 8'h00}, 8, 1'b0);
    frame({8'h01, 8'h04}, 16, 1'b0);
    check("R6 cannot clear lock", 8'h88);
  endtask

  task automatic t_short;
    wp_n = 1'b1;
    frame({8'h06, 8'h00}, 7, 1'b0);
    check("R8 short enable", 8'h88);
    frame({8'h06, 8'h00}, 8, 1'b0);
    frame({8'h01, 8'h3C}, 12, 1'b0);
    check("R8 R7 short write", 8'h88);
    frame({8'h06, 8'h00}, 8, 1'b0);
    frame({8'h01, 8'h3C}, 17, 1'b0);
    check("R8 long write", 8'h88);
  endtask

  task automatic t_idle_clock;
    for (int i = 0; i < 16; i++) begin
      mosi = i[0];
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
    end
    check("R11 idle clock", 8'h88);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_no_latch();
    t_mode0_write();
    t_mode3_write();
    t_locked();
    t_unprotect_clear();
    t_wp_low_set();
    t_short();
    t_idle_clock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule